// File: doc/BRIEF.md
# Two-Level Thermal Shutdown Controller

This block decides, for each of several output channels, whether the channel's power switch may conduct. It combines two independent protection levels. At the first level, each channel carries its own latched junction over-temperature bit, set by an "above shutdown" comparator and cleared by a separate, lower "below restart" comparator, which gives hysteresis. At the second level, a single chip-wide case temperature monitor trips on a case "above shutdown" comparator and, when it trips, holds off only those channels that are overloaded at that moment. Channels that carry no overload keep following their commands.

The case trip records the set of overloaded channels at the moment it occurs. That set stays held until the case "below reset" comparator reports that the case has cooled, and then all held channels are released in the same cycle. A common fault flag reports any junction shutdown. A separate warning flag reports the case trip. Temperature sensing and the analog comparators sit outside the block; it only consumes their digital outputs.

Top module: `thermGuard`

## Requirements
- R1: Each gate enable equals its channel command, combinationally and in the same cycle, when that channel has neither a junction latch nor a case hold.
- R2: A channel whose junction above-shutdown bit is sampled high at a clock edge has its junction latch set, and its gate enable is low from that edge onward whatever its command.
- R3: A junction latch stays set until that channel's below-restart bit is sampled high with its above-shutdown bit low; the latch then clears at that edge. When both bits are high together, the set wins.
- R4: When the case above-shutdown bit is sampled high while no case trip is latched, the overload vector sampled at that edge becomes the held set (bit i set means channel i held off). Held channels have their gate enable low from that edge onward.
- R5: During a case trip, channels outside the held set keep following their commands. Changes to the overload inputs during the trip do not change the held set.
- R6: While a case trip is latched, a clock edge that samples the below-reset bit high and the above-shutdown bit low ends the trip and releases every held channel together. If the above-shutdown bit is also high, the trip and the held set remain.
- R7: The fault output is high exactly while at least one junction latch is set.
- R8: The warning output is high exactly while a case trip is latched.
- R9: An active-low asynchronous reset clears all junction latches, the held set and the case trip, so that the fault and warning outputs read low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chCmd | input | NUM_CH | Per-channel on command |
| chOverload | input | NUM_CH | Per-channel overload (current limiting active) flag |
| junHot | input | NUM_CH | Per-channel junction above-shutdown comparator |
| junCool | input | NUM_CH | Per-channel junction below-restart comparator |
| caseHot | input | 1 | Case above-shutdown comparator |
| caseCool | input | 1 | Case below-reset comparator |
| gateEn | output | NUM_CH | Per-channel gate enable |
| faultOut | output | 1 | Common fault: any junction shutdown latched |
| tempWarn | output | 1 | Case over-temperature trip latched |

## Verification
The bench builds the block with NUM_CH set to 4. With that width, all sixteen overload vectors can be swept through a full case trip and release cycle, so every possible held set is captured, checked against later overload changes and released. The narrow width also keeps the junction priority case, where above-shutdown and below-restart are high together, and the overlap of a junction latch with a case hold on the same channel to a few short steps.

// File: rtl/thermPkg.sv
package thermPkg;
  typedef struct packed {
    logic captureCase;
    logic releaseCase;
  } caseStrobeT;

  typedef enum logic {
    CASE_OK   = 1'b0,
    CASE_TRIP = 1'b1
  } caseStateT;
endpackage

// File: rtl/thermCtrl.sv
module thermCtrl
  import thermPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       caseHot,
  input  logic       caseCool,
  output caseStrobeT strobe,
  output logic       tripped
);
  caseStateT state, stateNext;

  always_comb begin
    strobe.captureCase = (state == CASE_OK) && caseHot;
    strobe.releaseCase = (state == CASE_TRIP) && caseCool && !caseHot;
    stateNext = state;
    if (strobe.captureCase) stateNext = CASE_TRIP;
    else if (strobe.releaseCase) stateNext = CASE_OK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= CASE_OK;
    else state <= stateNext;
  end

  assign tripped = (state == CASE_TRIP);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.captureCase && strobe.releaseCase)); // R6
  AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (tripped && (!caseCool || caseHot)) |=> tripped); // R6
  AST_WARN_SET: assert property (@(posedge clk) disable iff (!rstN)
    caseHot |=> tripped); // R8
endmodule

// File: rtl/thermDatapath.sv
module thermDatapath
  import thermPkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  caseStrobeT        strobe,
  input  logic [NUM_CH-1:0] chCmd,
  input  logic [NUM_CH-1:0] chOverload,
  input  logic [NUM_CH-1:0] junHot,
  input  logic [NUM_CH-1:0] junCool,
  output logic [NUM_CH-1:0] gateEn,
  output logic              anyJunLatched
);
  logic [NUM_CH-1:0] junLatch;
  logic [NUM_CH-1:0] holdMask;

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) junLatch[g] <= 1'b0;
      else if (junHot[g]) junLatch[g] <= 1'b1;
      else if (junCool[g]) junLatch[g] <= 1'b0;
    end

    assign gateEn[g] = chCmd[g] && !junLatch[g] && !holdMask[g];

    AST_JUN_SET: assert property (@(posedge clk) disable iff (!rstN)
      junHot[g] |=> junLatch[g]); // R2
    AST_JUN_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      (junLatch[g] && !junCool[g]) |=> junLatch[g]); // R3
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdMask <= '0;
    else if (strobe.captureCase) holdMask <= chOverload;
    else if (strobe.releaseCase) holdMask <= '0;
  end

  assign anyJunLatched = |junLatch;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.captureCase && !strobe.releaseCase) |=> $stable(holdMask)); // R5
endmodule

// File: rtl/thermGuard.sv
module thermGuard
  import thermPkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chCmd,
  input  logic [NUM_CH-1:0] chOverload,
  input  logic [NUM_CH-1:0] junHot,
  input  logic [NUM_CH-1:0] junCool,
  input  logic              caseHot,
  input  logic              caseCool,
  output logic [NUM_CH-1:0] gateEn,
  output logic              faultOut,
  output logic              tempWarn
);
  caseStrobeT strobe;
  logic       tripped;
  logic       anyJun;

  thermCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .caseHot  (caseHot),
    .caseCool (caseCool),
    .strobe   (strobe),
    .tripped  (tripped)
  );

  thermDatapath #(.NUM_CH(NUM_CH)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .chCmd         (chCmd),
    .chOverload    (chOverload),
    .junHot        (junHot),
    .junCool       (junCool),
    .gateEn        (gateEn),
    .anyJunLatched (anyJun)
  );

  assign faultOut = anyJun;
  assign tempWarn = tripped;

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    AST_GATE_JUN_OFF: assert property (@(posedge clk) disable iff (!rstN)
      junHot[g] |=> !gateEn[g]); // R2
    AST_GATE_CASE_OFF: assert property (@(posedge clk) disable iff (!rstN)
      (!tempWarn && caseHot && chOverload[g]) |=> !gateEn[g]); // R4
  end

  AST_FAULT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (|junHot) |=> faultOut); // R7
endmodule

// File: tb/thermGuard_tb_top.sv
module thermGuard_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] chCmd = '0, chOverload = '0, junHot = '0, junCool = '0;
  logic caseHot = 1'b0, caseCool = 1'b0;
  logic [N-1:0] gateEn;
  logic faultOut, tempWarn;

  int total = 0;
  int bad = 0;

  logic [N-1:0] expGate[$];
  logic         expFault[$];
  logic         expWarn[$];
  string        expTag[$];

  logic [N-1:0] junM = '0, holdM = '0;
  logic         tripM = 1'b0;

  always #4 clk = ~clk;

  thermGuard #(.NUM_CH(N)) dut_i (
    .clk(clk), .rstN(rstN), .chCmd(chCmd), .chOverload(chOverload),
    .junHot(junHot), .junCool(junCool), .caseHot(caseHot), .caseCool(caseCool),
    .gateEn(gateEn), .faultOut(faultOut), .tempWarn(tempWarn)
  );

  task automatic check(input string tag, input logic [N-1:0] g, input logic f, input logic w,
                       input logic [N-1:0] eg, input logic ef, input logic ew);
    total++;
    if (g !== eg || f !== ef || w !== ew) begin
      bad++;
      $display("FAIL %s: gate=%b fault=%b warn=%b expected gate=%b fault=%b warn=%b",
               tag, g, f, w, eg, ef, ew);
    end
  endtask

  task automatic step(input logic [N-1:0] cmd, input logic [N-1:0] ovl,
                      input logic [N-1:0] jh, input logic [N-1:0] jc,
                      input logic ch, input logic cc, input string tag);
    logic [N-1:0] junN, holdN;
    logic tripN;
    @(negedge clk);
    chCmd = cmd; chOverload = ovl; junHot = jh; junCool = jc;
    caseHot = ch; caseCool = cc;
    junN = (junM | jh) & ~(jc & ~jh);
    holdN = holdM; tripN = tripM;
    if (!tripM && ch) begin holdN = ovl; tripN = 1'b1; end
    else if (tripM && cc && !ch) begin holdN = '0; tripN = 1'b0; end
    expGate.push_back(cmd & ~junN & ~holdN);
    expFault.push_back(|junN);
    expWarn.push_back(tripN);
    expTag.push_back(tag);
    junM = junN; holdM = holdN; tripM = tripN;
  endtask

  always @(posedge clk) begin
    #2;
    if (expTag.size() > 0)
      check(expTag.pop_front(), gateEn, faultOut, tempWarn,
            expGate.pop_front(), expFault.pop_front(), expWarn.pop_front());
  end

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog: run did not complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", gateEn, faultOut, tempWarn, '0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 after reset", gateEn, faultOut, tempWarn, '0, 1'b0, 1'b0);
    // R1: command passthrough, same-cycle check at negedge
    chCmd = 4'b1011; #1;
    check("R1 comb", gateEn, faultOut, tempWarn, 4'b1011, 1'b0, 1'b0);
    step(4'b0101, '0, '0, '0, 0, 0, "R1 pattern a");
    step(4'b1010, '0, '0, '0, 0, 0, "R1 pattern b");
    step(4'b1111, '0, '0, '0, 0, 0, "R1 all on");
    // R2 / R7: junction trip
    step(4'b1111, '0, 4'b0001, '0, 0, 0, "R2 junction set ch0");
    step(4'b1111, '0, '0, '0, 0, 0, "R3 latch held");
    step(4'b1111, '0, 4'b0001, 4'b0001, 0, 0, "R3 set wins over clear");
    step(4'b1111, '0, '0, 4'b0001, 0, 0, "R3 clear on restart");
    step(4'b1111, '0, 4'b1100, '0, 0, 0, "R7 two channels");
    step(4'b1111, '0, '0, 4'b0100, 0, 0, "R7 one remains");
    step(4'b1111, '0, '0, 4'b1000, 0, 0, "R7 fault clears");
    // R4 R5 R6 R8 sweep of every held set
    for (int p = 0; p < 16; p++) begin
      step(4'b1111, 4'(p), '0, '0, 1, 0, "R4 capture");
      step(4'b1111, 4'(~p), '0, '0, 0, 0, "R5 overload change ignored");
      step(4'b0110, 4'b1111, '0, '0, 1, 0, "R5 unheld follow cmd");
      step(4'b1111, '0, '0, '0, 1, 1, "R6 hot wins over cool");
      step(4'b1111, '0, '0, '0, 0, 1, "R6 release together");
      step(4'b1111, '0, '0, '0, 0, 0, "R8 warn clear");
    end
    // combined junction and case hold on one channel
    step(4'b1111, 4'b0010, 4'b0010, '0, 1, 0, "R4 with junction");
    step(4'b1111, '0, '0, 4'b0010, 0, 0, "R3 jun clear still case held");
    step(4'b1111, '0, '0, '0, 0, 1, "R6 final release");
    step(4'b0000, '0, '0, '0, 0, 0, "R1 all off");
    @(negedge clk); @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule